// File: doc/BRIEF.md
# Boot ROM Overlay Controller

This block sits between a processor bus and two read sources: a small on-chip boot image and an external cartridge ROM. Out of reset, every read whose address falls in the lowest 256-byte page is answered from the on-chip image, so the processor's first fetch at address 0x0000 runs boot code. Every other address is passed straight through to the cartridge bus.

The boot code ends with a store to the I/O location 0xFF50. That store sets a sticky flag that takes the overlay away. From the next cycle on, the low page is read from the cartridge. Only reset brings the overlay back. Because the store sits in the last two bytes of the page, the processor's next fetch at 0x0100 is already cartridge code, and its fetch stream never has to move.

The controller decodes addresses, steers the read-data multiplexer and gates the cartridge strobes. It holds one state bit, which it also drives out as a status output.

Top module: `boot_overlay_ctrl`

## Requirements
- R1: After reset `overlay_active` is 1.
- R2: While `overlay_active` is 1, a read of an address in 0x0000..0x00FF returns byte N of `BOOT_IMAGE`, where N is the low 8 address bits and byte N occupies bits [8N+7:8N]. `cart_rd` stays 0 for such a read. The default image holds `((7*N+3) mod 256) XOR 0x5A` at byte N.
- R3: A read of any address from 0x0100 upward, 0xFF50 included, returns `cart_rdata` and raises `cart_rd`. This holds whatever the state of the overlay.
- R4: A write to address 0xFF50 clears `overlay_active` at the next rising clock edge. The data value of the write makes no difference.
- R5: While `overlay_active` is 0, a read of 0x0000..0x00FF returns `cart_rdata` and raises `cart_rd`.
- R6: Once cleared, `overlay_active` stays 0 through any further writes to 0xFF50, whatever their data. Only reset sets it to 1 again.
- R7: A write to 0xFF50 never raises `cart_wr`. A write to any other address raises `cart_wr` in the same cycle.
- R8: In the cycle of the disabling write, `overlay_active` is still 1. A low-page read issued in the very next cycle is already served from the cartridge.
- R9: `cart_addr` always equals `cpu_addr`, and `cart_wdata` always equals `cpu_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; brings the overlay back |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rdata | output | 8 | Read data returned to the processor |
| cart_addr | output | 16 | Cartridge address |
| cart_wdata | output | 8 | Cartridge write data |
| cart_rd | output | 1 | Cartridge read strobe |
| cart_wr | output | 1 | Cartridge write strobe |
| cart_rdata | input | 8 | Cartridge read data |
| overlay_active | output | 1 | 1 while the low page is served by the boot image |

## Verification
Two functions meet at one clock edge: the flag update caused by the disabling write, and the routing of the low-page read that follows it. The bench provokes this by issuing the write to 0xFF50 and then, in the very next cycle with no idle cycle between, reading address 0x0000. It judges the write cycle by an overlay still active and a cartridge write strobe held low. It judges the following cycle by cartridge data and a raised cartridge read strobe. Sweeps of the whole low page and a strided set of high addresses, both before and after the disable, confirm that the routing changes only for the low page.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;

  localparam int unsigned DEF_PAGE_BITS = 8;
  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_IMG_W     = (1 << DEF_PAGE_BITS) * DEF_DATA_W;

  typedef enum logic {
    ROUTE_CART = 1'b0,
    ROUTE_BOOT = 1'b1
  } route_e;

  // Filler pattern for the default image; the bench restates it its own way.
  function automatic logic [7:0] seed_byte(input int unsigned idx);
    logic [7:0] lin;
    lin = 8'((idx * 7) + 3);
    return lin ^ 8'h5A;
  endfunction

  function automatic logic [DEF_IMG_W-1:0] default_image();
    logic [DEF_IMG_W-1:0] img;
    img = '0;
    for (int unsigned i = 0; i < (1 << DEF_PAGE_BITS); i++) begin
      img[i*DEF_DATA_W +: DEF_DATA_W] = seed_byte(i);
    end
    return img;
  endfunction

  // True when the address lies in the lowest page of the map.
  function automatic logic in_low_page(input logic [15:0] addr,
                                       input int unsigned page_bits);
    return (addr >> page_bits) == 16'h0000;
  endfunction

endpackage

// File: rtl/ovl_addr_decode.sv
module ovl_addr_decode
  import boot_ovl_pkg::*;
#(
  parameter int unsigned    ADDR_W       = 16,
  parameter int unsigned    PAGE_BITS    = 8,
  parameter logic [ADDR_W-1:0] DISABLE_ADDR = 16'hFF50
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              overlay_on,
  output logic              boot_hit,
  output logic              reg_wr_hit,
  output route_e            route,
  output logic              fwd_rd,
  output logic              fwd_wr
);

  localparam int unsigned HI_W = ADDR_W - PAGE_BITS;

  logic page_zero;

  assign page_zero  = (addr[ADDR_W-1:PAGE_BITS] == {HI_W{1'b0}});
  assign boot_hit   = page_zero && overlay_on;
  assign reg_wr_hit = wr && (addr == DISABLE_ADDR);
  assign route      = boot_hit ? ROUTE_BOOT : ROUTE_CART;
  assign fwd_rd     = rd && !boot_hit;
  assign fwd_wr     = wr && !reg_wr_hit;

endmodule

// File: rtl/ovl_sticky_flag.sv
module ovl_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_req,
  output logic active
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b1;
    end else if (clear_req) begin
      active <= 1'b0;
    end
  end

endmodule

// File: rtl/ovl_read_steer.sv
module ovl_read_steer
  import boot_ovl_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PAGE_BITS = 8,
  parameter logic [(2**PAGE_BITS)*DATA_W-1:0] BOOT_IMAGE = '0
) (
  input  route_e               route,
  input  logic [PAGE_BITS-1:0] page_idx,
  input  logic [DATA_W-1:0]    cart_rdata,
  output logic [DATA_W-1:0]    rdata
);

  localparam int unsigned PAGE_BYTES = 2 ** PAGE_BITS;

  logic [DATA_W-1:0] rom_bytes [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_rom
    assign rom_bytes[g] = BOOT_IMAGE[g*DATA_W +: DATA_W];
  end

  always_comb begin
    unique case (route)
      ROUTE_BOOT: rdata = rom_bytes[page_idx];
      default:    rdata = cart_rdata;
    endcase
  end

endmodule

// File: rtl/boot_overlay_ctrl.sv
module boot_overlay_ctrl
  import boot_ovl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PAGE_BITS = 8,
  parameter logic [ADDR_W-1:0] DISABLE_ADDR = 16'hFF50,
  parameter logic [(2**PAGE_BITS)*DATA_W-1:0] BOOT_IMAGE = default_image()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [ADDR_W-1:0] cart_addr,
  output logic [DATA_W-1:0] cart_wdata,
  output logic              cart_rd,
  output logic              cart_wr,
  input  logic [DATA_W-1:0] cart_rdata,
  output logic              overlay_active
);

  // Named internal events, visible to the bound checker.
  logic   boot_hit;
  logic   reg_wr_hit;
  route_e route;

  ovl_addr_decode #(
    .ADDR_W      (ADDR_W),
    .PAGE_BITS   (PAGE_BITS),
    .DISABLE_ADDR(DISABLE_ADDR)
  ) u_decode (
    .addr      (cpu_addr),
    .rd        (cpu_rd),
    .wr        (cpu_wr),
    .overlay_on(overlay_active),
    .boot_hit  (boot_hit),
    .reg_wr_hit(reg_wr_hit),
    .route     (route),
    .fwd_rd    (cart_rd),
    .fwd_wr    (cart_wr)
  );

  ovl_sticky_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_req(reg_wr_hit),
    .active   (overlay_active)
  );

  ovl_read_steer #(
    .DATA_W    (DATA_W),
    .PAGE_BITS (PAGE_BITS),
    .BOOT_IMAGE(BOOT_IMAGE)
  ) u_steer (
    .route     (route),
    .page_idx  (cpu_addr[PAGE_BITS-1:0]),
    .cart_rdata(cart_rdata),
    .rdata     (cpu_rdata)
  );

  assign cart_addr  = cpu_addr;
  assign cart_wdata = cpu_wdata;

endmodule

// File: rtl/boot_overlay_chk.sv
module boot_overlay_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_BITS = 8,
  parameter logic [ADDR_W-1:0] DISABLE_ADDR = 16'hFF50
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic              cart_rd,
  input logic              cart_wr,
  input logic              overlay_active,
  input logic              boot_hit,
  input logic              reg_wr_hit
);

  logic low_page;
  logic is_reg;
  assign low_page = (cpu_addr >> PAGE_BITS) == '0;
  assign is_reg   = (cpu_addr == DISABLE_ADDR);

  a_r2_boot_read_no_cart: assert property (@(posedge clk) disable iff (!rst_n)
    (overlay_active && cpu_rd && low_page) |-> !cart_rd);

  a_r3_high_read_to_cart: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !low_page) |-> (cart_rd && !boot_hit));

  a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && is_reg) |=> !overlay_active);

  a_r5_cart_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (!overlay_active && cpu_rd) |-> cart_rd);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !overlay_active |=> !overlay_active);

  a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    overlay_active |-> $past(overlay_active));

  a_r7_reg_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && is_reg) |-> !cart_wr);

  a_r7_other_write_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !is_reg) |-> cart_wr);

  a_r8_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overlay_active) |-> $past(reg_wr_hit));

endmodule

bind boot_overlay_ctrl boot_overlay_chk #(
  .ADDR_W      (ADDR_W),
  .PAGE_BITS   (PAGE_BITS),
  .DISABLE_ADDR(DISABLE_ADDR)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_addr      (cpu_addr),
  .cpu_rd        (cpu_rd),
  .cpu_wr        (cpu_wr),
  .cart_rd       (cart_rd),
  .cart_wr       (cart_wr),
  .overlay_active(overlay_active),
  .boot_hit      (boot_hit),
  .reg_wr_hit    (reg_wr_hit)
);

// File: tb/test_boot_overlay_ctrl.sv
`timescale 1ns/1ps
module test_boot_overlay_ctrl;

  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [15:0] cart_addr;
  logic [7:0]  cart_wdata;
  logic        cart_rd;
  logic        cart_wr;
  logic [7:0]  cart_rdata;
  logic        overlay_active;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  // Cartridge model: a byte derived from the address it is given.
  function automatic logic [7:0] cart_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign cart_rdata = cart_val(cart_addr);

  // Default boot image, restated: 7N+3 folded to a byte, then XOR 0x5A.
  function automatic logic [7:0] boot_val(input int n);
    int s;
    s = (n * 7 + 3) % 256;
    return s[7:0] ^ 8'h5A;
  endfunction

  boot_overlay_ctrl i_boot_overlay_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .cart_addr(cart_addr), .cart_wdata(cart_wdata), .cart_rd(cart_rd),
    .cart_wr(cart_wr), .cart_rdata(cart_rdata), .overlay_active(overlay_active)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, then let combinational outputs settle.
  task automatic drive(input logic [15:0] a, input logic rd, input logic wr, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #2;
  endtask

  task automatic sweep_low(input bit boot);
    for (int a = 0; a < 256; a++) begin
      drive(16'(a), 1'b1, 1'b0, 8'h00);
      if (boot) begin
        check("R2 rdata", cpu_rdata, boot_val(a));
        check("R2 cart_rd", cart_rd, 0);
      end else begin
        check("R5 rdata", cpu_rdata, cart_val(16'(a)));
        check("R5 cart_rd", cart_rd, 1);
      end
      check("R9 cart_addr", cart_addr, a);
    end
  endtask

  task automatic sweep_high();
    for (int a = 16'h0100; a <= 16'hFFFF; a += 16'h00FD) begin
      drive(16'(a), 1'b1, 1'b0, 8'h00);
      check("R3 rdata", cpu_rdata, cart_val(16'(a)));
      check("R3 cart_rd", cart_rd, 1);
    end
    drive(16'hFF50, 1'b1, 1'b0, 8'h00);
    check("R3 reg read rdata", cpu_rdata, cart_val(16'hFF50));
    check("R3 reg read cart_rd", cart_rd, 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #2;
    check("R1 overlay after reset", overlay_active, 1);
    check("R7 idle cart_wr", cart_wr, 0);

    sweep_low(1'b1);
    sweep_high();

    // Ordinary write is forwarded and leaves the overlay alone.
    drive(16'h8000, 1'b0, 1'b1, 8'h77);
    check("R7 other write cart_wr", cart_wr, 1);
    check("R9 cart_wdata", cart_wdata, 8'h77);
    check("R9 cart_addr write", cart_addr, 16'h8000);
    drive(16'h00FE, 1'b1, 1'b0, 8'h00);
    check("R4 no clear from other write", overlay_active, 1);
    check("R2 rdata at FE", cpu_rdata, boot_val(254));

    // Disabling write followed at once by a low-page read.
    drive(16'hFF50, 1'b0, 1'b1, 8'h01);
    check("R8 still active in write cycle", overlay_active, 1);
    check("R7 reg write blocked", cart_wr, 0);
    drive(16'h0000, 1'b1, 1'b0, 8'h00);
    check("R4 cleared", overlay_active, 0);
    check("R8 next read from cart", cpu_rdata, cart_val(16'h0000));
    check("R8 next read cart_rd", cart_rd, 1);

    sweep_low(1'b0);

    // Sticky: further writes of assorted data change nothing.
    for (int k = 0; k < 4; k++) begin
      drive(16'hFF50, 1'b0, 1'b1, 8'(k * 85));
      check("R7 repeat reg write blocked", cart_wr, 0);
      drive(16'h0010, 1'b1, 1'b0, 8'h00);
      check("R6 stays cleared", overlay_active, 0);
      check("R6 low read from cart", cpu_rdata, cart_val(16'h0010));
    end
    sweep_high();

    // Reset restores the overlay; data 0x00 still disables it.
    do_reset();
    check("R6 reset restores", overlay_active, 1);
    drive(16'h0042, 1'b1, 1'b0, 8'h00);
    check("R2 boot after re-reset", cpu_rdata, boot_val(66));
    drive(16'hFF50, 1'b0, 1'b1, 8'h00);
    drive(16'h0042, 1'b1, 1'b0, 8'h00);
    check("R4 zero data clears", overlay_active, 0);
    check("R5 cart after zero-data clear", cpu_rdata, cart_val(16'h0042));

    done = 1'b1;
    summary();
    $finish;
  end

endmodule